// File: doc/BRIEF.md
# Protected Fully Associative Address Translation Buffer

This block translates a 32-bit virtual address into a physical address by comparing the virtual page number against all of its entries at once. Each entry carries the owning process id, a physical page number, read/write/execute permissions, a supervisor-only flag, a shared flag, and dirty and reference bits. A lookup that finds a matching entry checks the requested access type against the entry's permissions and the requester's privilege. The block then answers one cycle later with a successful translation, a miss, or an access fault. Successful accesses update the entry's reference bit, and successful writes also update its dirty bit.

Entries are loaded through a single-cycle refill port. A refill overwrites an entry that already holds the same page number and process id. If there is none, it takes the lowest-numbered empty entry. If the buffer is full, a free-running LFSR picks a pseudo-random victim. On a context switch the whole buffer can be flushed. Alternatively, only the private entries of one process id can be purged, and shared entries survive.

Top module: `tlb_assoc_xlate`

## Requirements
- R1: After reset no entry is valid, all response outputs are 0, and the first lookup reports a miss.
- R2: A request sampled at a clock edge is answered at the next edge with `rsp_vld`=1. On a successful translation `rsp_paddr` = {entry physical page number, `req_vaddr[11:0]`}, where the virtual page number is `req_vaddr[31:12]`.
- R3: If no entry matches, the response is `rsp_miss`=1 with `rsp_paddr`, `rsp_dirty` and `rsp_ref` all 0.
- R4: A private entry matches only a request whose process id equals its own. An entry loaded with `fill_shared`=1 matches any process id.
- R5: Access codes are 0 = read, 1 = write, 2 = execute and 3 = reserved. In user mode a read needs `fill_perm[0]`, a write needs `fill_perm[1]`, and an execute needs `fill_perm[2]`; code 3 always fails. A failing check on a matching entry gives `rsp_afault`=1, never `rsp_miss`, with the address, dirty and reference outputs all 0.
- R6: A request with `req_sup`=1 bypasses the permission check. A user request to an entry loaded with `fill_sup_only`=1 raises an access fault.
- R7: A successful write sets the entry's dirty bit. `rsp_dirty` reports the bit as it was before the access. A faulting access leaves the bit unchanged.
- R8: Every successful translation sets the entry's reference bit, and `rsp_ref` reports the value before the access. A freshly loaded entry has both bits clear.
- R9: A refill whose page number and process id equal those of a valid entry overwrites that entry and does not add a second one.
- R10: A refill uses the lowest empty entry when one exists. With all entries valid it evicts exactly one entry, chosen by the LFSR.
- R11: `inv_all` invalidates every entry, and it takes precedence over a refill in the same cycle.
- R12: `inv_pid_en` invalidates the private entries whose process id equals `inv_pid`. Shared entries and entries of other processes stay valid.
- R13: When `rsp_vld`=1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_afault` is 1. When `rsp_vld`=0, none of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W (32) | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| req_sup | input | 1 | Requester is in supervisor mode |
| req_pid | input | PID_W (8) | Requesting process id |
| fill_en | input | 1 | Load an entry this cycle |
| fill_vpn | input | VA_W-OFF_W (20) | Virtual page number to load |
| fill_pid | input | PID_W (8) | Owning process id |
| fill_ppn | input | PPN_W (20) | Physical page number |
| fill_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| fill_sup_only | input | 1 | Page is reachable only in supervisor mode |
| fill_shared | input | 1 | Page is shared across processes |
| inv_all | input | 1 | Invalidate every entry |
| inv_pid_en | input | 1 | Purge the private entries of one process |
| inv_pid | input | PID_W (8) | Process id to purge |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | Successful translation |
| rsp_miss | output | 1 | No matching entry |
| rsp_afault | output | 1 | Matching entry refused the access |
| rsp_paddr | output | PPN_W+OFF_W (32) | Physical address, 0 unless hit |
| rsp_dirty | output | 1 | Dirty bit before this access |
| rsp_ref | output | 1 | Reference bit before this access |

## Verification
The hardest case to reach from the ports is the random eviction, because the victim depends on the free-running LFSR phase, which the bench cannot see. The stimulus first flushes the buffer and fills all sixteen entries, confirming that none is lost while free slots exist. It then loads a seventeenth page and probes every loaded page. The check does not predict which entry was evicted: it requires the new page to translate correctly and exactly one of the old pages to miss. Dirty and reference tracking is observed via the prior-value outputs across repeated accesses to the same page, including accesses that fault.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_t;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;
  localparam int PERM_BITS = 3;
endpackage

// File: rtl/tlb_lfsr.sv
// Free-running Galois LFSR; its low bits name the eviction slot (R10).
module tlb_lfsr #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [OUT_W-1:0] pick
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= W'(1);
    end else if (state_q[0]) begin
      state_q <= (state_q >> 1) ^ TAPS;
    end else begin
      state_q <= state_q >> 1;
    end
  end

  assign pick = state_q[OUT_W-1:0];
endmodule

// File: rtl/tlb_prienc.sv
// Lowest-index-first priority encoder.
module tlb_prienc #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_cam.sv
// Parallel comparators: lookup match (R4), refill duplicate (R9), purge (R12).
module tlb_cam #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PID_W = 8
) (
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     ent_shared,
  input  logic [VPN_W-1:0] ent_vpn [N],
  input  logic [PID_W-1:0] ent_pid [N],
  input  logic [VPN_W-1:0] look_vpn,
  input  logic [PID_W-1:0] look_pid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PID_W-1:0] fill_pid,
  input  logic [PID_W-1:0] purge_pid,
  output logic [N-1:0]     look_vec,
  output logic [N-1:0]     dup_vec,
  output logic [N-1:0]     purge_vec
);
  for (genvar gi = 0; gi < N; gi++) begin : g_cmp
    logic pid_eq_look;
    assign pid_eq_look   = (ent_pid[gi] == look_pid);
    assign look_vec[gi]  = ent_valid[gi] && (ent_vpn[gi] == look_vpn) &&
                           (ent_shared[gi] || pid_eq_look);
    assign dup_vec[gi]   = ent_valid[gi] && (ent_vpn[gi] == fill_vpn) &&
                           (ent_pid[gi] == fill_pid);
    assign purge_vec[gi] = ent_valid[gi] && !ent_shared[gi] &&
                           (ent_pid[gi] == purge_pid);
  end
endmodule

// File: rtl/tlb_prot.sv
// Access permission check (R5, R6).
module tlb_prot
  import tlb_pkg::*;
(
  input  logic [PERM_BITS-1:0] perm,
  input  logic                 sup_only,
  input  logic                 sup,
  input  acc_t                 acc,
  output logic                 ok
);
  always_comb begin
    if (sup) begin
      ok = 1'b1;
    end else if (sup_only) begin
      ok = 1'b0;
    end else begin
      case (acc)
        ACC_RD:  ok = perm[PERM_R];
        ACC_WR:  ok = perm[PERM_W];
        ACC_EX:  ok = perm[PERM_X];
        default: ok = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tlb_assoc_xlate.sv
module tlb_assoc_xlate
  import tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int PID_W   = 8,
  parameter int LFSR_W  = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PPN_W + OFF_W,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_vld,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic [1:0]           req_acc,
  input  logic                 req_sup,
  input  logic [PID_W-1:0]     req_pid,
  input  logic                 fill_en,
  input  logic [VPN_W-1:0]     fill_vpn,
  input  logic [PID_W-1:0]     fill_pid,
  input  logic [PPN_W-1:0]     fill_ppn,
  input  logic [PERM_BITS-1:0] fill_perm,
  input  logic                 fill_sup_only,
  input  logic                 fill_shared,
  input  logic                 inv_all,
  input  logic                 inv_pid_en,
  input  logic [PID_W-1:0]     inv_pid,
  output logic                 rsp_vld,
  output logic                 rsp_hit,
  output logic                 rsp_miss,
  output logic                 rsp_afault,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_dirty,
  output logic                 rsp_ref
);
  // entry state
  logic [NUM_ENT-1:0]   valid_q, dirty_q, ref_q, shared_q, suponly_q;
  logic [VPN_W-1:0]     vpn_q  [NUM_ENT];
  logic [PID_W-1:0]     pid_q  [NUM_ENT];
  logic [PPN_W-1:0]     ppn_q  [NUM_ENT];
  logic [PERM_BITS-1:0] perm_q [NUM_ENT];

  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  assign look_vpn = req_vaddr[VA_W-1:OFF_W];
  assign look_off = req_vaddr[OFF_W-1:0];

  // match logic
  logic [NUM_ENT-1:0] look_vec, dup_vec, purge_vec, free_vec;

  tlb_cam #(.N(NUM_ENT), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam (
    .ent_valid (valid_q),
    .ent_shared(shared_q),
    .ent_vpn   (vpn_q),
    .ent_pid   (pid_q),
    .look_vpn  (look_vpn),
    .look_pid  (req_pid),
    .fill_vpn  (fill_vpn),
    .fill_pid  (fill_pid),
    .purge_pid (inv_pid),
    .look_vec  (look_vec),
    .dup_vec   (dup_vec),
    .purge_vec (purge_vec)
  );

  assign free_vec = ~valid_q;

  logic             look_any, dup_any, free_any;
  logic [IDX_W-1:0] look_idx, dup_idx, free_idx, rnd_idx, vic_idx;

  tlb_prienc #(.N(NUM_ENT), .IW(IDX_W)) u_enc_look (
    .vec(look_vec), .any(look_any), .idx(look_idx));
  tlb_prienc #(.N(NUM_ENT), .IW(IDX_W)) u_enc_dup (
    .vec(dup_vec), .any(dup_any), .idx(dup_idx));
  tlb_prienc #(.N(NUM_ENT), .IW(IDX_W)) u_enc_free (
    .vec(free_vec), .any(free_any), .idx(free_idx));

  tlb_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .OUT_W(IDX_W)) u_lfsr (
    .clk(clk), .rst(rst), .pick(rnd_idx));

  // victim: existing same page/pid, else lowest free, else random
  always_comb begin
    if (dup_any)       vic_idx = dup_idx;
    else if (free_any) vic_idx = free_idx;
    else               vic_idx = rnd_idx;
  end

  // permission check
  acc_t acc;
  logic prot_ok;
  assign acc = acc_t'(req_acc);

  tlb_prot u_prot (
    .perm    (perm_q[look_idx]),
    .sup_only(suponly_q[look_idx]),
    .sup     (req_sup),
    .acc     (acc),
    .ok      (prot_ok)
  );

  logic look_ok, look_bad, fill_do;
  assign look_ok  = req_vld && look_any && prot_ok;
  assign look_bad = req_vld && look_any && !prot_ok;
  assign fill_do  = fill_en && !inv_all;

  // next valid vector: flush beats purge beats refill
  logic [NUM_ENT-1:0] valid_nxt;
  always_comb begin
    valid_nxt = valid_q;
    if (fill_do)    valid_nxt[vic_idx] = 1'b1;
    if (inv_pid_en) valid_nxt = valid_nxt & ~purge_vec;
    if (inv_all)    valid_nxt = '0;
  end

  // status bits with reset
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else begin
      valid_q <= valid_nxt;
      if (look_ok) begin
        ref_q[look_idx] <= 1'b1;
        if (acc == ACC_WR) dirty_q[look_idx] <= 1'b1;
      end
      if (fill_do) begin
        dirty_q[vic_idx] <= 1'b0;
        ref_q[vic_idx]   <= 1'b0;
      end
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (fill_do) begin
      vpn_q[vic_idx]     <= fill_vpn;
      pid_q[vic_idx]     <= fill_pid;
      ppn_q[vic_idx]     <= fill_ppn;
      perm_q[vic_idx]    <= fill_perm;
      shared_q[vic_idx]  <= fill_shared;
      suponly_q[vic_idx] <= fill_sup_only;
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld    <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_afault <= 1'b0;
      rsp_paddr  <= '0;
      rsp_dirty  <= 1'b0;
      rsp_ref    <= 1'b0;
    end else begin
      rsp_vld    <= req_vld;
      rsp_hit    <= look_ok;
      rsp_miss   <= req_vld && !look_any;
      rsp_afault <= look_bad;
      rsp_paddr  <= look_ok ? {ppn_q[look_idx], look_off} : '0;
      rsp_dirty  <= look_ok ? dirty_q[look_idx] : 1'b0;
      rsp_ref    <= look_ok ? ref_q[look_idx] : 1'b0;
    end
  end
endmodule

// File: rtl/tlb_assoc_xlate_chk.sv
module tlb_assoc_xlate_chk #(
  parameter int NUM_ENT = 16,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               req_vld,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               fill_en,
  input logic               inv_all,
  input logic               inv_pid_en,
  input logic               rsp_vld,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_afault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [NUM_ENT-1:0] valid_q,
  input logic [NUM_ENT-1:0] dup_vec
);
  a_r13_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_vld |-> ($countones({rsp_hit, rsp_miss, rsp_afault}) == 1));

  a_r13_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> !(rsp_hit || rsp_miss || rsp_afault));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  a_r2_offset_pass: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  a_r3_zero_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss || rsp_afault) |-> (rsp_paddr == '0));

  a_r11_flush_all: assert property (@(posedge clk) disable iff (rst)
    inv_all |=> (valid_q == '0));

  a_r12_purge_shrinks: assert property (@(posedge clk) disable iff (rst)
    (inv_pid_en && !fill_en) |=> ($countones(valid_q) <= $past($countones(valid_q))));

  a_r9_no_duplicate: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dup_vec));
endmodule

bind tlb_assoc_xlate tlb_assoc_xlate_chk #(
  .NUM_ENT(NUM_ENT), .VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_vld   (req_vld),
  .req_vaddr (req_vaddr),
  .fill_en   (fill_en),
  .inv_all   (inv_all),
  .inv_pid_en(inv_pid_en),
  .rsp_vld   (rsp_vld),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_afault(rsp_afault),
  .rsp_paddr (rsp_paddr),
  .valid_q   (valid_q),
  .dup_vec   (dup_vec)
);

// File: tb/test_tlb_assoc_xlate.sv
`timescale 1ns/1ps
module test_tlb_assoc_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_sup = 1'b0;
  logic [7:0]  req_pid = '0;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [7:0]  fill_pid = '0;
  logic [19:0] fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_sup_only = 1'b0;
  logic        fill_shared = 1'b0;
  logic        inv_all = 1'b0;
  logic        inv_pid_en = 1'b0;
  logic [7:0]  inv_pid = '0;
  logic        rsp_vld, rsp_hit, rsp_miss, rsp_afault, rsp_dirty, rsp_ref;
  logic [31:0] rsp_paddr;

  always #10 clk = ~clk;

  tlb_assoc_xlate i_tlb_assoc_xlate (
    .clk(clk), .rst(rst),
    .req_vld(req_vld), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .req_sup(req_sup), .req_pid(req_pid),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .fill_sup_only(fill_sup_only), .fill_shared(fill_shared),
    .inv_all(inv_all), .inv_pid_en(inv_pid_en), .inv_pid(inv_pid),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_afault(rsp_afault), .rsp_paddr(rsp_paddr),
    .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref)
  );

  typedef struct {
    logic        hit, miss, af;
    logic [31:0] pa;
    logic        d, r;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  function automatic exp_t mk(logic h, logic m, logic a, logic [31:0] pa,
                              logic d, logic r, string tag);
    exp_t e;
    e.hit = h; e.miss = m; e.af = a; e.pa = pa; e.d = d; e.r = r; e.tag = tag;
    return e;
  endfunction

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops scoreboard entries as responses arrive
  always @(negedge clk) begin
    if (rsp_vld && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (rsp_hit !== e.hit || rsp_miss !== e.miss || rsp_afault !== e.af ||
          rsp_paddr !== e.pa || rsp_dirty !== e.d || rsp_ref !== e.r) begin
        fails++;
        $display("FAIL %s: got hit=%0b miss=%0b af=%0b pa=%h d=%0b r=%0b exp hit=%0b miss=%0b af=%0b pa=%h d=%0b r=%0b",
                 e.tag, rsp_hit, rsp_miss, rsp_afault, rsp_paddr, rsp_dirty, rsp_ref,
                 e.hit, e.miss, e.af, e.pa, e.d, e.r);
      end
    end
  end

  task automatic idle_drv;
    req_vld = 0; fill_en = 0; inv_all = 0; inv_pid_en = 0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [11:0] off,
                      input logic [7:0] pid, input logic [1:0] acc,
                      input logic sup, input exp_t e);
    @(negedge clk);
    idle_drv();
    req_vld = 1; req_vaddr = {vpn, off}; req_pid = pid; req_acc = acc; req_sup = sup;
    sb_q.push_back(e);
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [7:0] pid,
                      input logic [19:0] ppn, input logic [2:0] perm,
                      input logic sup_only, input logic shared);
    @(negedge clk);
    idle_drv();
    fill_en = 1; fill_vpn = vpn; fill_pid = pid; fill_ppn = ppn;
    fill_perm = perm; fill_sup_only = sup_only; fill_shared = shared;
  endtask

  task automatic flush;
    @(negedge clk);
    idle_drv();
    inv_all = 1;
  endtask

  task automatic purge(input logic [7:0] pid);
    @(negedge clk);
    idle_drv();
    inv_pid_en = 1; inv_pid = pid;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      idle_drv();
    end
  endtask

  // direct probe, used where the expected outcome is not known per lookup
  task automatic probe(input logic [19:0] vpn, input logic [7:0] pid,
                       output logic hit, output logic [31:0] pa);
    @(negedge clk);
    idle_drv();
    req_vld = 1; req_vaddr = {vpn, 12'h000}; req_pid = pid; req_acc = 2'd0; req_sup = 0;
    @(negedge clk);
    idle_drv();
    hit = rsp_hit;
    pa  = rsp_paddr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    report();
  end

  initial begin
    logic        h;
    logic [31:0] pa;
    int          old_miss;

    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs idle after reset
    checks++;
    if ({rsp_vld, rsp_hit, rsp_miss, rsp_afault, rsp_dirty, rsp_ref} !== 6'b0 ||
        rsp_paddr !== 32'h0) begin
      fails++;
      $display("FAIL R1 reset outputs: got vld=%0b pa=%h expected 0", rsp_vld, rsp_paddr);
    end
    look(20'h12345, 12'h000, 8'd1, 2'd0, 0, mk(0,1,0,0,0,0, "R1 first lookup misses"));

    fill(20'h12345, 8'd1, 20'hABCDE, 3'b011, 0, 0);
    look(20'h12345, 12'h678, 8'd1, 2'd0, 0, mk(1,0,0,32'hABCDE678,0,0, "R2 translate R8 fresh"));
    look(20'h12345, 12'hFFF, 8'd1, 2'd0, 0, mk(1,0,0,32'hABCDEFFF,0,1, "R2 offset R8 ref set"));
    look(20'h12345, 12'h004, 8'd1, 2'd1, 0, mk(1,0,0,32'hABCDE004,0,1, "R7 write prior clean"));
    look(20'h12345, 12'h008, 8'd1, 2'd0, 0, mk(1,0,0,32'hABCDE008,1,1, "R7 dirty after write"));
    look(20'h12345, 12'h000, 8'd1, 2'd2, 0, mk(0,0,1,0,0,0, "R5 exec not permitted"));
    look(20'h12345, 12'h000, 8'd1, 2'd3, 0, mk(0,0,1,0,0,0, "R5 reserved code faults"));
    look(20'h12346, 12'h000, 8'd1, 2'd0, 0, mk(0,1,0,0,0,0, "R3 other page misses"));
    look(20'h12345, 12'h000, 8'd2, 2'd0, 0, mk(0,1,0,0,0,0, "R4 private pid mismatch"));

    fill(20'h00400, 8'd5, 20'h00077, 3'b100, 0, 1);
    look(20'h00400, 12'h010, 8'd9, 2'd2, 0, mk(1,0,0,32'h00077010,0,0, "R4 shared any pid"));
    look(20'h00400, 12'h010, 8'd9, 2'd0, 0, mk(0,0,1,0,0,0, "R5 read on exec-only"));
    look(20'h00400, 12'h010, 8'd9, 2'd1, 0, mk(0,0,1,0,0,0, "R5 write on exec-only"));
    look(20'h00400, 12'h020, 8'd9, 2'd2, 0, mk(1,0,0,32'h00077020,0,1, "R7 fault left clean"));

    fill(20'h00500, 8'd1, 20'h11111, 3'b111, 1, 0);
    look(20'h00500, 12'h000, 8'd1, 2'd0, 0, mk(0,0,1,0,0,0, "R6 user to sup-only page"));
    look(20'h00500, 12'h0AA, 8'd1, 2'd1, 1, mk(1,0,0,32'h111110AA,0,0, "R6 supervisor write"));
    fill(20'h00600, 8'd1, 20'h22222, 3'b000, 0, 0);
    look(20'h00600, 12'h001, 8'd1, 2'd2, 1, mk(1,0,0,32'h22222001,0,0, "R6 sup bypasses perms"));
    look(20'h00600, 12'h001, 8'd1, 2'd0, 0, mk(0,0,1,0,0,0, "R5 user no perms"));

    // R9: refill same page and pid overwrites
    fill(20'h12345, 8'd1, 20'h33333, 3'b001, 0, 0);
    look(20'h12345, 12'h100, 8'd1, 2'd0, 0, mk(1,0,0,32'h33333100,0,0, "R9 overwrite clears bits"));
    look(20'h12345, 12'h100, 8'd1, 2'd1, 0, mk(0,0,1,0,0,0, "R9 new perms in force"));
    fill(20'h12345, 8'd2, 20'h44444, 3'b001, 0, 0);
    look(20'h12345, 12'h200, 8'd2, 2'd0, 0, mk(1,0,0,32'h44444200,0,0, "R9 other pid separate"));

    // R12: purge pid 3
    fill(20'h00700, 8'd3, 20'h55555, 3'b001, 0, 0);
    fill(20'h00800, 8'd3, 20'h66666, 3'b001, 0, 1);
    purge(8'd3);
    look(20'h00700, 12'h000, 8'd3, 2'd0, 0, mk(0,1,0,0,0,0, "R12 private purged"));
    look(20'h00800, 12'h000, 8'd3, 2'd0, 0, mk(1,0,0,32'h66666000,0,0, "R12 shared kept"));
    look(20'h12345, 12'h000, 8'd1, 2'd0, 0, mk(1,0,0,32'h33333000,0,1, "R12 pid1 kept"));
    look(20'h12345, 12'h000, 8'd2, 2'd0, 0, mk(1,0,0,32'h44444000,0,1, "R12 pid2 kept"));

    // R11: flush everything
    flush();
    look(20'h12345, 12'h000, 8'd1, 2'd0, 0, mk(0,1,0,0,0,0, "R11 flushed pid1"));
    look(20'h00400, 12'h000, 8'd5, 2'd2, 0, mk(0,1,0,0,0,0, "R11 flushed shared"));
    look(20'h00500, 12'h000, 8'd1, 2'd0, 1, mk(0,1,0,0,0,0, "R11 flushed sup page"));

    // R10: fill all slots, then one more
    for (int i = 0; i < 16; i++) fill(20'h01000 + 20'(i), 8'd7, 20'h08000 + 20'(i), 3'b001, 0, 0);
    for (int i = 0; i < 16; i++)
      look(20'h01000 + 20'(i), 12'h000, 8'd7, 2'd0, 0,
           mk(1,0,0,{20'h08000 + 20'(i), 12'h000},0,0, "R10 free slots kept all"));
    fill(20'h02000, 8'd7, 20'h09000, 3'b001, 0, 0);
    idle(2);
    probe(20'h02000, 8'd7, h, pa);
    checks++;
    if (h !== 1'b1 || pa !== 32'h09000000) begin
      fails++;
      $display("FAIL R10 new page: got hit=%0b pa=%h expected hit=1 pa=09000000", h, pa);
    end
    old_miss = 0;
    for (int i = 0; i < 16; i++) begin
      probe(20'h01000 + 20'(i), 8'd7, h, pa);
      if (!h) old_miss++;
      else if (pa !== {20'h08000 + 20'(i), 12'h000}) begin
        checks++;
        fails++;
        $display("FAIL R10 survivor addr: got %h expected %h", pa, {20'h08000 + 20'(i), 12'h000});
      end
    end
    checks++;
    if (old_miss != 1) begin
      fails++;
      $display("FAIL R10 evictions: got %0d expected 1", old_miss);
    end

    idle(3);
    checks++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL R2 missing responses: got %0d pending expected 0", sb_q.size());
    end
    report();
  end
endmodule